// File: doc/BRIEF.md
# Event Flag Interrupt Request Controller

This block gathers one-cycle event pulses from three timekeeping sources (alarm match, periodic tick, update-ended) into sticky flags. It also holds a matching set of enable bits. An interrupt request is raised whenever at least one flag is set and its enable is also set. The request pin is open-drain. The block therefore never drives it high: it either pulls the pad low or lets it float, and an external pull-up supplies the idle level.

Software services the interrupt by reading the status word. The read returns the flags as they stood before the read. A summary bit in the same word mirrors the request line. The same read wipes every flag, and the line is released on the following cycle. A pulse that lands in the same cycle as the read is not lost: its flag shows up after the clear. Reset clears both the flags and the enable bits, so the pad floats for as long as reset is held.

Top module: `irqfe_ctrl`

## Requirements
- R1: While `rst_n` is low, all flags and enable bits are zero, `irq_oe` is 0 and `stat_rdata` is 0. This holds even when reset arrives in the middle of operation.
- R2: A 1 on `evt_pulse[i]` sets flag i at the next rising edge, whatever the enables hold. The flag stays set until a status read. Flag positions are: 0 alarm, 1 periodic, 2 update-ended.
- R3: `irq_oe` is 1 exactly when some flag i is set and enable bit i is also set. A set flag whose enable is 0 leaves `irq_oe` at 0.
- R4: `irq_dout` is 0 at all times, so the pad is only ever pulled low or released.
- R5: `stat_rdata` shows the current flags in bits [2:0] and the summary (OR of flag AND enable) in bit 7. Bits [6:3] are 0. During a read cycle, `stat_rdata` shows the values from before the clear.
- R6: A cycle with `stat_rd` high clears every flag at the next rising edge, and `irq_oe` falls unless a new enabled event arrives in that same cycle.
- R7: An event pulse that coincides with `stat_rd` leaves its flag set after the clear.
- R8: `en_wr` loads `en_wdata` into the enable bits at the next rising edge and leaves the flags unchanged. Enabling a flag that is already set raises `irq_oe`.
- R9: While `stat_rd` is low, the flags are never cleared, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 3 | One-cycle event pulses (bit 0 alarm, 1 periodic, 2 update-ended) |
| en_wr | input | 1 | Enable-bit write strobe |
| en_wdata | input | 3 | New enable bits |
| stat_rd | input | 1 | Status read strobe (read clears flags) |
| stat_rdata | output | 8 | Status word: flags in [2:0], summary in [7] |
| irq_oe | output | 1 | Pad output enable; 1 pulls the request line low |
| irq_dout | output | 1 | Pad data value, constant 0 |

## Verification
The hardest case to reach is an event pulse that falls in exactly the cycle of a status read. That one case has to show the old flags on the read data, clear the rest, and still keep the new flag. The stimulus drives the pulse and the read strobe together in one step after earlier flags have been set. It also repeats the collision with the incoming source masked, so that the line is released while the new flag survives. A reset asserted in the middle of operation while an enabled flag holds the line low is the other case the bench forces on purpose.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

  localparam int MAX_SRC = 16;

  typedef enum logic [1:0] {
    SRC_ALARM    = 2'd0,
    SRC_PERIODIC = 2'd1,
    SRC_UPDATE   = 2'd2
  } irq_src_e;

  // Next flag value for one source: read clears, a pulse sets after the clear.
  function automatic logic flag_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  // Summary: any source both flagged and enabled.
  function automatic logic any_armed(input logic [MAX_SRC-1:0] flags,
                                     input logic [MAX_SRC-1:0] en);
    return |(flags & en);
  endfunction

endpackage

// File: rtl/irqfe_flag_bank.sv
module irqfe_flag_bank #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr,
  output logic [NUM_SRC-1:0] flags
);
  import irqfe_pkg::*;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], clr, evt[i]);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |-> flags == '0)
    else $error("flags not clear in reset");

  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(evt)) == $past(evt)))
    else $error("event pulse did not set flag");

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> flags == '0)
    else $error("read did not clear flags");

  assert_collide_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> flags == $past(evt))
    else $error("colliding event lost or stale flag kept");

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)))
    else $error("flag dropped without read");

endmodule

// File: rtl/irqfe_enable_reg.sv
module irqfe_enable_reg #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (wr) en <= wdata;
  end

  assert_en_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> en == $past(wdata))
    else $error("enable write not taken");

  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en))
    else $error("enable changed without write");

endmodule

// File: rtl/irqfe_status_view.sv
module irqfe_status_view #(
  parameter int NUM_SRC = 3,
  parameter int STAT_W  = 8
) (
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] en,
  output logic [STAT_W-1:0]  rdata,
  output logic               summary
);
  import irqfe_pkg::*;

  localparam int SUM_BIT = STAT_W - 1;

  logic [MAX_SRC-1:0] flags_w, en_w;

  always_comb begin
    flags_w = '0;
    en_w    = '0;
    flags_w[NUM_SRC-1:0] = flags;
    en_w[NUM_SRC-1:0]    = en;
    summary = any_armed(flags_w, en_w);
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b < NUM_SRC) begin : g_flag
      assign rdata[b] = flags[b];
    end else if (b == SUM_BIT) begin : g_sum
      assign rdata[b] = summary;
    end else begin : g_zero
      assign rdata[b] = 1'b0;
    end
  end

endmodule

// File: rtl/irqfe_ctrl.sv
module irqfe_ctrl #(
  parameter int NUM_SRC = 3,
  parameter int STAT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic               en_wr,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               stat_rd,
  output logic [STAT_W-1:0]  stat_rdata,
  output logic               irq_oe,
  output logic               irq_dout
);

  localparam int SUM_BIT = STAT_W - 1;

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] en;
  logic               summary;
  logic               read_clear;

  assign read_clear = stat_rd;

  irqfe_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_pulse),
    .clr   (read_clear),
    .flags (flags)
  );

  irqfe_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (en_wr),
    .wdata (en_wdata),
    .en    (en)
  );

  irqfe_status_view #(.NUM_SRC(NUM_SRC), .STAT_W(STAT_W)) u_view (
    .flags   (flags),
    .en      (en),
    .rdata   (stat_rdata),
    .summary (summary)
  );

  // Open-drain pad: enable pulls low, data is tied to zero.
  assign irq_oe   = summary;
  assign irq_dout = 1'b0;

  assert_reset_release_R1: assert property (@(posedge clk) !rst_n |-> !irq_oe)
    else $error("pad driven during reset");

  assert_line_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[SUM_BIT] == irq_oe)
    else $error("summary bit differs from pad enable");

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_pulse == '0) |=> !irq_oe)
    else $error("line still pulled after read");

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en) == '0) |-> !irq_oe)
    else $error("pad pulled with nothing armed");

endmodule

// File: tb/irqfe_ctrl_bench.sv
module irqfe_ctrl_bench;
  localparam int N = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] evt_pulse, en_wdata;
  logic         en_wr, stat_rd;
  logic [W-1:0] stat_rdata;
  logic         irq_oe, irq_dout;

  irqfe_ctrl #(.NUM_SRC(N), .STAT_W(W)) u_irqfe_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .en_wr(en_wr),
    .en_wdata(en_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .irq_oe(irq_oe), .irq_dout(irq_dout)
  );

  typedef struct {
    logic [W-1:0] rdata;
    logic         oe;
    string        tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad   = 0;
  logic [N-1:0] m_flags = '0;
  logic [N-1:0] m_en    = '0;

  // Status word per R5: summary at bit 7, zeros at [6:3], flags at [2:0].
  function automatic logic [W-1:0] expect_word(logic [N-1:0] f, logic [N-1:0] e);
    logic [W-1:0] w;
    w = '0;
    for (int k = 0; k < N; k++) w[k] = f[k];
    w[W-1] = ((f & e) != 0);
    return w;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] evt, bit rd, bit wr, logic [N-1:0] wd, string tag);
    exp_t e;
    @(negedge clk);
    evt_pulse = evt; stat_rd = rd; en_wr = wr; en_wdata = wd;
    e.rdata = expect_word(m_flags, m_en);
    e.oe    = ((m_flags & m_en) != 0);
    e.tag   = tag;
    q.push_back(e);
    if (rd) m_flags = '0;
    m_flags = m_flags | evt;
    if (wr) m_en = wd;
  endtask

  // Monitor: compares each cycle's outputs with the queued expectation.
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1 && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(stat_rdata === e.rdata, e.tag, "stat_rdata", stat_rdata, e.rdata);
      check(irq_oe === e.oe, e.tag, "irq_oe", irq_oe, e.oe);
      check(irq_dout === 1'b0, "R4", "irq_dout", irq_dout, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_pulse = '0; stat_rd = 0; en_wr = 0; en_wdata = '0;
    repeat (2) @(negedge clk);
    #2;
    check(irq_oe === 1'b0, "R1", "irq_oe in reset", irq_oe, 0);
    check(stat_rdata === '0, "R1", "stat_rdata in reset", stat_rdata, 0);
    @(negedge clk); rst_n = 1'b1;

    step(3'b000, 0, 1, 3'b111, "R8");   // enable all
    step(3'b001, 0, 0, 3'b000, "R2");   // alarm pulse
    step(3'b000, 0, 0, 3'b000, "r2_r3");  // flag visible, line low
    step(3'b000, 0, 0, 3'b000, "R9");   // still held without read
    step(3'b000, 1, 0, 3'b000, "R5");   // read shows pre-clear word
    step(3'b000, 0, 0, 3'b000, "R6");   // cleared, released
    step(3'b000, 0, 1, 3'b010, "R8");   // only periodic enabled
    step(3'b001, 0, 0, 3'b000, "R3");   // alarm masked
    step(3'b000, 0, 0, 3'b000, "R3");   // flag set, line released
    step(3'b000, 0, 1, 3'b011, "R8");   // enable alarm late
    step(3'b000, 0, 0, 3'b000, "R8");   // line now pulled
    step(3'b100, 1, 0, 3'b000, "R7");   // read collides with update pulse
    step(3'b000, 0, 0, 3'b000, "R7");   // update flag survived, masked
    step(3'b000, 0, 1, 3'b111, "R8");
    step(3'b011, 0, 0, 3'b000, "R2");   // two pulses at once
    step(3'b000, 0, 0, 3'b000, "R5");   // all three flags
    step(3'b010, 1, 0, 3'b000, "R7");   // collision with enabled source
    step(3'b000, 0, 0, 3'b000, "R7");   // line stays low for new flag
    step(3'b000, 1, 0, 3'b000, "R6");
    for (int k = 0; k < 4; k++) step(3'b000, 0, 0, 3'b000, "R9");
    step(3'b101, 0, 0, 3'b000, "R2");
    step(3'b000, 0, 0, 3'b000, "R3");
    repeat (2) @(negedge clk);
    #4;

    // Mid-run reset while the line is pulled low.
    check(irq_oe === 1'b1, "R3", "irq_oe before reset", irq_oe, 1);
    rst_n = 1'b0;
    #1;
    check(irq_oe === 1'b0, "R1", "irq_oe after async reset", irq_oe, 0);
    check(stat_rdata === '0, "R1", "stat_rdata after async reset", stat_rdata, 0);
    q.delete();
    m_flags = '0; m_en = '0;
    @(negedge clk); rst_n = 1'b1;
    step(3'b001, 0, 0, 3'b000, "R1");  // enables cleared by reset
    step(3'b000, 0, 0, 3'b000, "R1");
    repeat (2) @(negedge clk);
    #4;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule